// File: doc/BRIEF.md
# Dual-Width Transceiver Data Path Adapter

This block connects a serial interface engine (SIE) to a byte-wide transceiver core. It offers the SIE two data path shapes, chosen by a width select input. In the narrow shape the sixteen data pins are split into two fixed lanes. The low lane carries transmit bytes into the block, and the high lane carries received bytes out of it. In the wide shape the same pins form one shared bus that carries a 16-bit word in either direction. A high-byte qualifier travels with the word and turns around with the bus.

On the transmit side the block splits each SIE word into one or two bytes for the core and tells the SIE when the word has been taken. On the receive side it joins core bytes into words. When a packet ends on an odd byte, it flushes the leftover byte as a half word. The core's byte-rate strobe sets the pace. That strobe fires every clock in narrow operation and every second clock in wide operation, so the whole block runs in one clock domain. Direction control is kept separate: the block drives the shared pins only while the SIE is not transmitting.

Top module: `utmi_width_adapter`

## Requirements
- R1: After a synchronous reset, `sie_rxvalid` and `sie_rxactive` are 0. With `sie_txvalid` low, `sie_txready` and `core_tx_load` are also 0.
- R2: Narrow path (`wide_sel`=0). In a cycle with `byte_stb` and `sie_txvalid` both high, `core_tx_load` and `sie_txready` are 1 and `core_tx_byte` equals `sie_din[7:0]`, all in that same cycle.
- R3: Narrow path, receive. A core byte accepted on a strobe cycle appears on `sie_dout[15:8]` in the next cycle, with `sie_rxvalid` high and `sie_dout[7:0]`=0. Throughout the narrow path, `sie_dout_oe` is 16'hFF00 and `sie_hiv_oe` is 0.
- R4: Wide path (`wide_sel`=1), word with `sie_hiv_in`=1. The first strobe passes `sie_din[7:0]` to the core with `sie_txready` low. The next strobe passes `sie_din[15:8]` with `sie_txready` high.
- R5: Wide path, word with `sie_hiv_in`=0. Only `sie_din[7:0]` goes to the core, and `sie_txready` is high on that single strobe.
- R6: Wide path, receive. Two bytes accepted on successive strobes are presented the cycle after the second one as {second, first}, with `sie_rxvalid`=1 and `sie_hiv_out`=1.
- R7: Wide path. If `core_rx_active` is low while one byte is held, the next cycle presents that byte on bits 7:0 with bits 15:8 zero, `sie_hiv_out`=0 and `sie_rxvalid`=1.
- R8: Wide path. `sie_dout_oe` is all ones and `sie_hiv_oe` is 1 exactly when `sie_txvalid` is low and `sie_rxvalid` is high. Otherwise both are 0, so the bus is never driven while the SIE transmits.
- R9: While `sie_txvalid` is low, `core_tx_load` and `sie_txready` are 0. The next word then starts with its low byte.
- R10: `sie_rxactive` follows `core_rx_active` one cycle later. It stays high for one extra cycle when an odd byte is flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_sel | input | 1 | 0 = split 8-bit lanes, 1 = shared 16-bit bus |
| byte_stb | input | 1 | Core byte-rate strobe |
| sie_txvalid | input | 1 | SIE transmit word valid |
| sie_txready | output | 1 | Current transmit word taken |
| sie_din | input | 16 | Data pins, input side |
| sie_hiv_in | input | 1 | High-byte qualifier from SIE (wide transmit) |
| sie_dout | output | 16 | Data pins, output side |
| sie_dout_oe | output | 16 | Per-bit output enable for data pins |
| sie_hiv_out | output | 1 | High-byte qualifier to SIE (wide receive) |
| sie_hiv_oe | output | 1 | Output enable of the qualifier pin |
| sie_rxvalid | output | 1 | Receive word/byte valid |
| sie_rxactive | output | 1 | Receive packet in progress |
| core_tx_byte | output | 8 | Byte handed to the core |
| core_tx_load | output | 1 | Core takes `core_tx_byte` this cycle |
| core_rx_byte | input | 8 | Byte from the core |
| core_rx_valid | input | 1 | Core byte valid (taken on strobe) |
| core_rx_active | input | 1 | Core receiving a packet |

## Verification
Several rules are checked by the assertions on every cycle. The bus and the qualifier are never driven while transmit-valid is high, and the narrow lane enables stay fixed. A paired byte or a flushed odd byte always yields a receive word of the right qualifier on the next cycle. A held upper half is always followed by the high byte, and the transmit side stays quiet while transmit-valid is low. The bench scenarios are needed for the rest. Only they show the exact byte values and their order after packing and unpacking, the ready timing of mixed full and half words under an alternating strobe, and the odd-byte flush at a real packet end.

// File: rtl/utmi_adp_pkg.sv
package utmi_adp_pkg;

    localparam int LANE_W = 8;
    localparam int WORD_W = 2 * LANE_W;

    typedef enum logic {
        PATH_NARROW = 1'b0,
        PATH_WIDE   = 1'b1
    } path_e;

    typedef struct packed {
        logic              valid;
        logic              hi_ok;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    function automatic logic [WORD_W-1:0] join_lanes(input logic [LANE_W-1:0] hi,
                                                     input logic [LANE_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/utmi_tx_unpack.sv
module utmi_tx_unpack
    import utmi_adp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  path_e             path,
    input  logic              stb,
    input  logic              txvalid,
    input  logic [WORD_W-1:0] din,
    input  logic              hiv_in,
    output logic [LANE_W-1:0] core_byte,
    output logic              core_load,
    output logic              txready
);

    logic upper_q;

    always_comb begin
        core_load = stb & txvalid;
        core_byte = (path == PATH_WIDE && upper_q) ? din[WORD_W-1:LANE_W] : din[LANE_W-1:0];
        txready   = core_load & ((path != PATH_WIDE) | upper_q | ~hiv_in);
    end

    always_ff @(posedge clk) begin
        if (rst || !txvalid)
            upper_q <= 1'b0;
        else if (stb && path == PATH_WIDE)
            upper_q <= ~upper_q & hiv_in;
    end

    // R9: no byte moves and no acknowledge without a transmit word
    a_r9_tx_quiet: assert property (@(posedge clk) disable iff (rst)
        !txvalid |-> (!core_load && !txready));

    // R4: after a first half with no acknowledge, the high byte is presented
    a_r4_upper_follows: assert property (@(posedge clk) disable iff (rst)
        (path == PATH_WIDE && stb && txvalid && hiv_in && !txready)
        |=> (!txvalid || core_byte == din[WORD_W-1:LANE_W]));

endmodule

// File: rtl/utmi_rx_pack.sv
module utmi_rx_pack
    import utmi_adp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  path_e             path,
    input  logic              stb,
    input  logic              cvalid,
    input  logic [LANE_W-1:0] cbyte,
    input  logic              cactive,
    output rx_word_t          rx,
    output logic              rxactive
);

    logic              have_lo;
    logic [LANE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx       <= '0;
            rxactive <= 1'b0;
            have_lo  <= 1'b0;
            lo_q     <= '0;
        end else begin
            rx.valid <= 1'b0;
            rxactive <= cactive | have_lo;
            if (path == PATH_NARROW) begin
                if (stb && cvalid) begin
                    rx.valid <= 1'b1;
                    rx.hi_ok <= 1'b0;
                    rx.data  <= join_lanes(cbyte, '0);
                end
            end else if (stb && cvalid) begin
                if (have_lo) begin
                    rx.valid <= 1'b1;
                    rx.hi_ok <= 1'b1;
                    rx.data  <= join_lanes(cbyte, lo_q);
                    have_lo  <= 1'b0;
                end else begin
                    lo_q    <= cbyte;
                    have_lo <= 1'b1;
                end
            end else if (have_lo && !cactive) begin
                rx.valid <= 1'b1;
                rx.hi_ok <= 1'b0;
                rx.data  <= join_lanes('0, lo_q);
                have_lo  <= 1'b0;
            end
        end
    end

    // R6: a completed byte pair yields a full word next cycle
    a_r6_pair_word: assert property (@(posedge clk) disable iff (rst)
        (path == PATH_WIDE && stb && cvalid && have_lo) |=> (rx.valid && rx.hi_ok));

    // R7: a stranded byte at packet end is flushed as a half word
    a_r7_odd_flush: assert property (@(posedge clk) disable iff (rst)
        (path == PATH_WIDE && have_lo && !cactive && !(stb && cvalid))
        |=> (rx.valid && !rx.hi_ok && rx.data[WORD_W-1:LANE_W] == '0));

    // R10: activity is reported one cycle after the core
    a_r10_active_follow: assert property (@(posedge clk) disable iff (rst)
        cactive |=> rxactive);

endmodule

// File: rtl/utmi_bus_dir.sv
module utmi_bus_dir
    import utmi_adp_pkg::*;
(
    input  path_e             path,
    input  logic              txvalid,
    input  logic              rxvalid,
    output logic [WORD_W-1:0] data_oe,
    output logic              hiv_oe
);

    localparam int NUM_LANES = WORD_W / LANE_W;

    logic turn_out;
    assign turn_out = !txvalid && rxvalid;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic lane_en;
        if (g == 0) begin : g_low
            assign lane_en = (path == PATH_WIDE) && turn_out;
        end else begin : g_high
            assign lane_en = (path == PATH_NARROW) || turn_out;
        end
        assign data_oe[g*LANE_W +: LANE_W] = {LANE_W{lane_en}};
    end

    assign hiv_oe = (path == PATH_WIDE) && turn_out;

endmodule

// File: rtl/utmi_width_adapter.sv
module utmi_width_adapter
    import utmi_adp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_sel,
    input  logic              byte_stb,
    input  logic              sie_txvalid,
    output logic              sie_txready,
    input  logic [WORD_W-1:0] sie_din,
    input  logic              sie_hiv_in,
    output logic [WORD_W-1:0] sie_dout,
    output logic [WORD_W-1:0] sie_dout_oe,
    output logic              sie_hiv_out,
    output logic              sie_hiv_oe,
    output logic              sie_rxvalid,
    output logic              sie_rxactive,
    output logic [LANE_W-1:0] core_tx_byte,
    output logic              core_tx_load,
    input  logic [LANE_W-1:0] core_rx_byte,
    input  logic              core_rx_valid,
    input  logic              core_rx_active
);

    path_e    path;
    rx_word_t rx;

    assign path = path_e'(wide_sel);

    utmi_tx_unpack u_tx (
        .clk       (clk),
        .rst       (rst),
        .path      (path),
        .stb       (byte_stb),
        .txvalid   (sie_txvalid),
        .din       (sie_din),
        .hiv_in    (sie_hiv_in),
        .core_byte (core_tx_byte),
        .core_load (core_tx_load),
        .txready   (sie_txready)
    );

    utmi_rx_pack u_rx (
        .clk      (clk),
        .rst      (rst),
        .path     (path),
        .stb      (byte_stb),
        .cvalid   (core_rx_valid),
        .cbyte    (core_rx_byte),
        .cactive  (core_rx_active),
        .rx       (rx),
        .rxactive (sie_rxactive)
    );

    utmi_bus_dir u_dir (
        .path    (path),
        .txvalid (sie_txvalid),
        .rxvalid (rx.valid),
        .data_oe (sie_dout_oe),
        .hiv_oe  (sie_hiv_oe)
    );

    assign sie_dout    = rx.data;
    assign sie_hiv_out = rx.hi_ok;
    assign sie_rxvalid = rx.valid;

    // R8: the shared bus is released whenever the SIE transmits
    a_r8_no_clash: assert property (@(posedge clk) disable iff (rst)
        (wide_sel && sie_txvalid) |-> (sie_dout_oe == '0 && !sie_hiv_oe));

    // R3: split lanes keep a fixed direction
    a_r3_split_lanes: assert property (@(posedge clk) disable iff (rst)
        !wide_sel |-> (sie_dout_oe == {{LANE_W{1'b1}}, {LANE_W{1'b0}}} && !sie_hiv_oe));

endmodule

// File: tb/utmi_width_adapter_tb_top.sv
module utmi_width_adapter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_sel = 1'b0;
    logic        byte_stb = 1'b0;
    logic        sie_txvalid = 1'b0;
    logic        sie_txready;
    logic [15:0] sie_din = '0;
    logic        sie_hiv_in = 1'b0;
    logic [15:0] sie_dout;
    logic [15:0] sie_dout_oe;
    logic        sie_hiv_out;
    logic        sie_hiv_oe;
    logic        sie_rxvalid;
    logic        sie_rxactive;
    logic [7:0]  core_tx_byte;
    logic        core_tx_load;
    logic [7:0]  core_rx_byte = '0;
    logic        core_rx_valid = 1'b0;
    logic        core_rx_active = 1'b0;

    always #4 clk = ~clk;

    utmi_width_adapter dut_i (.*);

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    // behavioural reference state
    int         m_hi = 0;
    byte        pend_q[$];
    logic       e_rxv = 0, e_act = 0, e_hiv = 0;
    logic [15:0] e_word = '0;
    logic       rdy_seen = 0, last_stb = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_hi = 0; pend_q.delete(); e_rxv = 0; e_act = 0; e_hiv = 0; e_word = '0;
        end else begin
            if (!sie_txvalid) m_hi = 0;
            else if (byte_stb && wide_sel) m_hi = (m_hi == 0 && sie_hiv_in) ? 1 : 0;
            e_act = core_rx_active || (pend_q.size() != 0);
            e_rxv = 0;
            if (!wide_sel) begin
                if (byte_stb && core_rx_valid) begin
                    e_rxv = 1; e_hiv = 0; e_word = {core_rx_byte, 8'h00};
                end
            end else if (byte_stb && core_rx_valid) begin
                if (pend_q.size() == 0) pend_q.push_back(core_rx_byte);
                else begin
                    e_rxv = 1; e_hiv = 1; e_word = {core_rx_byte, 8'(pend_q.pop_front())};
                end
            end else if (pend_q.size() != 0 && !core_rx_active) begin
                e_rxv = 1; e_hiv = 0; e_word = {8'h00, 8'(pend_q.pop_front())};
            end
        end
    end

    always begin
        @(negedge clk);
        #2;
        begin
            logic       x_load, x_rdy;
            logic [7:0] x_byte;
            string      ttag, rtag;
            x_load = byte_stb && sie_txvalid;
            x_byte = (wide_sel && m_hi == 1) ? sie_din[15:8] : sie_din[7:0];
            x_rdy  = x_load && (!wide_sel || m_hi == 1 || !sie_hiv_in);
            ttag = rst ? "R1" : !sie_txvalid ? "R9" : !wide_sel ? "R2" :
                   (m_hi == 0 && !sie_hiv_in) ? "R5" : "R4";
            rtag = rst ? "R1" : !wide_sel ? "R3" : (e_rxv && !e_hiv) ? "R7" : "R6";
            chk({ttag, " tx_load"}, core_tx_load, x_load);
            chk({ttag, " tx_ready"}, sie_txready, x_rdy);
            if (x_load) chk({ttag, " tx_byte"}, core_tx_byte, x_byte);
            chk({rtag, " rxvalid"}, sie_rxvalid, e_rxv);
            chk(rst ? "R1 rxactive" : "R10 rxactive", sie_rxactive, e_act);
            if (e_rxv && !rst) begin
                chk({rtag, " rx_data"}, sie_dout, e_word);
                if (wide_sel) chk({rtag, " rx_hiv"}, sie_hiv_out, e_hiv);
            end
            if (!rst) begin
                if (!wide_sel) begin
                    chk("R3 data_oe", sie_dout_oe, 16'hFF00);
                    chk("R3 hiv_oe", sie_hiv_oe, 0);
                end else begin
                    chk("R8 data_oe", sie_dout_oe, (!sie_txvalid && e_rxv) ? 16'hFFFF : 16'h0);
                    chk("R8 hiv_oe", sie_hiv_oe, !sie_txvalid && e_rxv);
                end
            end
        end
    end

    task automatic step();
        byte_stb = wide_sel ? ~byte_stb : 1'b1;
        #3;
        rdy_seen = sie_txready;
        last_stb = byte_stb;
        @(negedge clk);
    endtask

    task automatic send_word(logic [15:0] w, logic h);
        sie_txvalid = 1'b1; sie_din = w; sie_hiv_in = h;
        do step(); while (!rdy_seen);
    endtask

    task automatic rx_byte(logic [7:0] b);
        core_rx_active = 1'b1; core_rx_valid = 1'b1; core_rx_byte = b;
        do step(); while (!last_stb);
        core_rx_valid = 1'b0;
    endtask

    task automatic end_pkt();
        core_rx_active = 1'b0; core_rx_valid = 1'b0;
        repeat (4) step();
    endtask

    task automatic do_reset(logic w);
        rst = 1'b1; wide_sel = w; byte_stb = 1'b0; sie_txvalid = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 rxvalid after reset", sie_rxvalid, 0);
        chk("R1 rxactive after reset", sie_rxactive, 0);
        chk("R1 txready after reset", sie_txready, 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        // narrow transmit
        send_word(16'h0011, 1'b0);
        send_word(16'h00E7, 1'b1);
        send_word(16'h005A, 1'b0);
        sie_txvalid = 1'b0; step(); step();
        // narrow receive
        core_rx_active = 1'b1; step();
        rx_byte(8'h3C); rx_byte(8'hC3); rx_byte(8'h81);
        end_pkt();
        // wide path
        do_reset(1'b1);
        send_word(16'hA1B2, 1'b1);
        send_word(16'h0033, 1'b0);
        send_word(16'hC4D5, 1'b1);
        send_word(16'h7E44, 1'b0);
        sie_txvalid = 1'b0; repeat (3) step();
        // wide receive, even packet
        core_rx_active = 1'b1; step();
        rx_byte(8'h12); rx_byte(8'h34); rx_byte(8'h56); rx_byte(8'h78);
        end_pkt();
        // wide receive, odd packet
        core_rx_active = 1'b1; step();
        rx_byte(8'h9A); rx_byte(8'hBC); rx_byte(8'hDE);
        end_pkt();
        // single-byte packet
        rx_byte(8'hF0);
        end_pkt();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule